// File: doc/BRIEF.md
# Two-Channel Input Change Interrupt Generator

This block produces the interrupt for a general-purpose input unit with two channels of eight inputs each, such as banks of push buttons. Each input passes through a two-flop synchroniser. A change is found by comparing the synchronised value with its value one cycle earlier. Any change on a channel, either a press (0 to 1) or a release (1 to 0), sets that channel's status flag.

The flags are gated at two levels. A per-channel enable selects which flags count, and a global enable switches the whole request on or off. The result is one interrupt request line that goes to a system interrupt controller. Software uses a simple memory-mapped register port to set the enables, read the synchronised inputs and status, and clear status flags by writing ones. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `gpio_irq_gen`

## Requirements
- R1: After reset, the global enable, both channel enables and both status flags are 0, and `irq` is low.
- R2: The synchronised inputs of channel 1 read at offset 0x000 and those of channel 2 at offset 0x008, in bits 7:0 with the upper bits 0. A new pin value is readable after the second rising edge that follows it.
- R3: Any change on any input of a channel sets that channel's status flag, whether the input rises or falls. Status is at offset 0x120: bit 0 is channel 1 and bit 1 is channel 2. The flag is set at the third rising edge after the pin changes. Inputs that stay unchanged set no flag.
- R4: The global enable is bit 31 of offset 0x11C. It can be written and read back, and the other bits of that register read as 0.
- R5: The channel enables are at offset 0x128: bit 0 is channel 1 and bit 1 is channel 2. They can be written and read back, and the other bits read as 0.
- R6: Writing 1 to a status bit clears it at that edge. Writing 0 to a status bit leaves it unchanged.
- R7: `irq` equals the global enable AND the OR over both channels of (status AND channel enable). It follows the status and enable registers in the same cycle.
- R8: If a change and a clearing write reach the same status bit at the same edge, the bit stays set.
- R9: Reads from any offset that is not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch1_in | input | 8 | Channel 1 input pins (asynchronous) |
| ch2_in | input | 8 | Channel 2 input pins (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational from `addr`) |
| irq | output | 1 | Interrupt request |

## Verification
A pin change reaches the data registers after two rising edges and the status flag after three. `irq` and `rdata` are combinational from the registers, so they settle in the same cycle the registers change. The bench drives a pin just after a falling edge, waits three rising edges, and only then reads at the next falling edge. Writes are driven at a falling edge and so land on the following rising edge. For the same-edge case (R8), the bench places the clearing write on exactly the third rising edge after a pin change, so that it meets the change as it arrives.

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
  parameter int CH_W   = 8,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   ch1_in,
  input  logic [CH_W-1:0]   ch2_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DAT1 = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_DAT2 = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(12'h11C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h120);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(12'h128);

  logic [1:0][CH_W-1:0] pin, s1, s2, s3;
  logic [1:0] chg, status, ch_en;
  logic       gie;

  assign pin = {ch2_in, ch1_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_chg
    assign chg[i] = |(s2[i] ^ s3[i]);
  end

  wire wr_gie  = wr_en && addr == A_GIE;
  wire wr_cen  = wr_en && addr == A_CEN;
  wire wr_stat = wr_en && addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie    <= 1'b0;
      ch_en  <= '0;
      status <= '0;
    end else begin
      if (wr_gie) gie <= wdata[DATA_W-1];
      if (wr_cen) ch_en <= wdata[1:0];
      status <= (status & ~(wr_stat ? wdata[1:0] : 2'b00)) | chg;
    end
  end

  assign irq = gie & |(status & ch_en);

  always_comb begin
    rdata = '0;
    case (addr)
      A_DAT1: rdata[CH_W-1:0] = s2[0];
      A_DAT2: rdata[CH_W-1:0] = s2[1];
      A_GIE:  rdata[DATA_W-1] = gie;
      A_STAT: rdata[1:0]      = status;
      A_CEN:  rdata[1:0]      = ch_en;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_gen_chk.sv
module gpio_irq_gen_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              gie,
  input logic [1:0]        ch_en,
  input logic [1:0]        status,
  input logic [1:0]        chg,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h120);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(12'h128);

  p_irq_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  p_change_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg[0] |=> status[0]);

  p_change_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg[1] && wr_en && addr == A_STAT && wdata[1]) |=> status[1]);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata[0] && !chg[0]) |=> !status[0]);

  p_status_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == A_STAT) && chg == 2'b00) |=> status == $past(status));

  p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CEN) |=> $stable(ch_en));
endmodule

bind gpio_irq_gen gpio_irq_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .gie(gie), .ch_en(ch_en),
  .status(status), .chg(chg), .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/gpio_irq_gen_bench.sv
`timescale 1ns/1ps
module gpio_irq_gen_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [7:0]  ch1_in = 0, ch2_in = 0;
  logic [8:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_gen u_gpio_irq_gen (.clk(clk), .rst_n(rst_n), .ch1_in(ch1_in), .ch2_in(ch2_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // {ch1, ch2, expected status}
  localparam int NV = 5;
  localparam logic [17:0] VEC [NV] = '{
    {8'h01, 8'h00, 2'b01},
    {8'h00, 8'h00, 2'b01},
    {8'h00, 8'h80, 2'b10},
    {8'hFF, 8'h7F, 2'b11},
    {8'hFF, 8'h7F, 2'b00}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #2 d = rdata;
  endtask

  task automatic pins(logic [7:0] a, logic [7:0] b);
    @(negedge clk); ch1_in = a; ch2_in = b;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    rd(12'h11C, v); chk("R1 gie", v, 0);
    rd(12'h128, v); chk("R1 ch_en", v, 0);
    rd(12'h120, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      pins(VEC[i][17:10], VEC[i][9:2]);
      rd(12'h120, v); chk("R3 status vector", v, {30'b0, VEC[i][1:0]});
      rd(12'h000, v); chk("R2 ch1 data", v, {24'b0, VEC[i][17:10]});
      rd(12'h008, v); chk("R2 ch2 data", v, {24'b0, VEC[i][9:2]});
      wr(12'h120, 32'h3);
      rd(12'h120, v); chk("R6 ack clears", v, 0);
    end

    wr(12'h11C, 32'hFFFF_FFFF); rd(12'h11C, v); chk("R4 gie readback", v, 32'h8000_0000);
    wr(12'h128, 32'hFFFF_FFFF); rd(12'h128, v); chk("R5 en readback", v, 32'h3);
    wr(12'h128, 32'h1);

    pins(8'hFF, 8'h00);
    rd(12'h120, v); chk("R7 status ch2 only", v, 32'h2);
    chk("R7 irq masked channel", {31'b0, irq}, 0);
    pins(8'hFE, 8'h00);
    #2 chk("R7 irq enabled channel", {31'b0, irq}, 1);
    wr(12'h11C, 32'h0); #2 chk("R7 irq global off", {31'b0, irq}, 0);
    wr(12'h11C, 32'h8000_0000); #2 chk("R7 irq global on", {31'b0, irq}, 1);
    wr(12'h120, 32'h0); rd(12'h120, v); chk("R6 write zero keeps", v, 32'h3);
    wr(12'h120, 32'h1); #2 chk("R7 irq after ack", {31'b0, irq}, 0);
    wr(12'h128, 32'h3); #2 chk("R7 irq ch2 enabled", {31'b0, irq}, 1);
    wr(12'h120, 32'h3);

    // R8: change lands at the same edge as the clearing write
    pins(8'hFE, 8'h01);
    rd(12'h120, v); chk("R8 pre status", v, 32'h2);
    @(negedge clk); ch2_in = 8'h03;
    repeat (2) @(posedge clk);
    wr(12'h120, 32'h2);
    rd(12'h120, v); chk("R8 change beats ack", v, 32'h2);
    wr(12'h120, 32'h2);
    rd(12'h120, v); chk("R8 later ack clears", v, 32'h0);

    rd(12'h004, v); chk("R9 unmapped", v, 0);
    rd(12'h124, v); chk("R9 unmapped", v, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule